// File: doc/BRIEF.md
# Ethernet ARP Request Responder

This block listens to a byte-wide stream of received Ethernet frames and answers address-resolution requests for its own IPv4 address. Each received byte comes with a valid flag, and a frame is the run of bytes during which that flag stays high. Preamble and FCS are not checked. When a frame is an Ethernet/IPv4 ARP request whose target protocol address equals the static local IPv4 address, the block captures the requester's MAC and IPv4 addresses. It then hands them from the receive clock domain to the transmit clock domain and emits a 60-byte ARP reply on a separate byte-wide transmit stream.

The receive side is a three-state machine. RX_IDLE waits for valid. On the first byte it goes to RX_PARSE, or to RX_DRAIN when that byte is rejected. RX_PARSE moves to RX_DRAIN on a mismatching byte or after the 42nd byte, and returns to RX_IDLE when valid falls early. RX_DRAIN returns to RX_IDLE once valid is low.

The transmit side is also a three-state machine. TX_IDLE moves to TX_OFFER when a reply is handed over. TX_OFFER moves to TX_SEND when the consumer acknowledges. TX_SEND returns to TX_IDLE after the last byte. The two domains exchange a toggle request and a toggle acknowledge through synchroniser chains, and they share one asynchronous reset.

Top module: `arp_reply_engine`

## Requirements
- R1: For an accepted request, the reply carries these bytes in this order, every multi-byte field most significant byte first:
  - requester MAC
  - local MAC
  - 0x0806
  - 0x0001
  - 0x0800
  - 0x06
  - 0x04
  - opcode 0x0002
  - local MAC
  - local IPv4
  - requester MAC
  - requester IPv4
- R2: The reply is exactly 60 bytes long, and bytes 42 to 59 are zero.
- R3: tx_valid rises when a reply is ready. While waiting for the one-cycle tx_ack, the block holds byte 0 on tx_data. After the ack, bytes 1 to 59 follow one per tx_clk. tx_valid falls after byte 59.
- R4: A frame whose EtherType is not 0x0806, such as an IPv4 frame of 64 or 94 bytes, produces no reply, and the next request is still answered.
- R5: A request whose target IPv4 (bytes 38 to 41) differs from local_ip produces no reply.
- R6: A request with hardware type other than 0x0001, protocol type other than 0x0800, lengths other than 6 and 4, or opcode other than 0x0001 produces no reply.
- R7: The destination MAC (bytes 0 to 5) must be all ones or equal to local_mac. Otherwise there is no reply.
- R8: A frame whose valid falls before its 42nd byte is discarded without a reply.
- R9: Bytes after the 42nd byte of a matching request are ignored, and the reply is unchanged.
- R10: A request that completes while a reply is still pending or being sent is dropped and never answered.
- R11: Asynchronous reset forces tx_valid low and clears any pending reply.
- R12: Requests sent one after another are each answered once the previous reply has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_async | input | 1 | Asynchronous reset for both domains, active high |
| local_mac | input | 48 | Static local MAC address |
| local_ip | input | 32 | Static local IPv4 address |
| rx_clk | input | 1 | Receive clock |
| rx_valid | input | 1 | Receive byte qualifier; high for the whole frame |
| rx_data | input | 8 | Received byte |
| tx_clk | input | 1 | Transmit clock |
| tx_ack | input | 1 | One-cycle acknowledge from the consumer |
| tx_valid | output | 1 | Reply frame present |
| tx_data | output | 8 | Reply byte |

## Verification
The bench targets the bytes where a parser most easily goes wrong:
- The last target-address byte. A comparator that is off by one answers foreign addresses.
- The second EtherType byte of an IPv4 frame. Checking only the first byte makes the block reply to data traffic.
- A frame that is cut short. A parser that does not leave RX_PARSE on a falling valid merges it with the next frame.

It also checks that a request arriving during a pending reply is dropped rather than overwriting the captured addresses, so a corrupted reply or a spurious second frame would be seen. It checks that a reset in TX_OFFER cancels the reply and does not leave the request toggle out of step, which would otherwise block every later reply.

// File: rtl/arp_resp_pkg.sv
package arp_resp_pkg;

    localparam int ARP_BYTES = 42;

    typedef enum logic [1:0] {RX_IDLE, RX_PARSE, RX_DRAIN} rx_state_t;
    typedef enum logic [1:0] {TX_IDLE, TX_OFFER, TX_SEND} tx_state_t;

    typedef struct packed {
        logic [47:0] mac;
        logic [31:0] ip;
    } peer_t;

    // byte k (0 = most significant) of a MAC address
    function automatic logic [7:0] mac_byte(input logic [47:0] m, input int k);
        logic [47:0] s;
        s = m << (8 * k);
        return s[47:40];
    endfunction

    function automatic logic [7:0] ip_byte(input logic [31:0] a, input int k);
        logic [31:0] s;
        s = a << (8 * k);
        return s[31:24];
    endfunction

    // constant ARP header bytes at frame offsets 12..21
    function automatic logic [7:0] fixed_hdr(input int i, input logic is_reply);
        case (i)
            12, 16:  return 8'h08;
            13:      return 8'h06;
            15:      return 8'h01;
            18:      return 8'h06;
            19:      return 8'h04;
            21:      return is_reply ? 8'h02 : 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] reply_byte(input int i, input logic [47:0] me_mac,
                                              input logic [31:0] me_ip, input peer_t p);
        if (i < 6)       return mac_byte(p.mac, i);
        else if (i < 12) return mac_byte(me_mac, i - 6);
        else if (i < 22) return fixed_hdr(i, 1'b1);
        else if (i < 28) return mac_byte(me_mac, i - 22);
        else if (i < 32) return ip_byte(me_ip, i - 28);
        else if (i < 38) return mac_byte(p.mac, i - 32);
        else if (i < 42) return ip_byte(p.ip, i - 38);
        else             return 8'h00;
    endfunction

endpackage

// File: rtl/arp_rx_parser.sv
module arp_rx_parser
    import arp_resp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_async,
    input  logic        valid,
    input  logic [7:0]  data,
    input  logic [47:0] my_mac,
    input  logic [31:0] my_ip,
    input  logic        busy,
    output logic        commit,
    output peer_t       peer
);
    localparam int CNT_W = $clog2(ARP_BYTES);
    localparam int LAST  = ARP_BYTES - 1;

    rx_state_t        st, st_nx;
    logic [CNT_W-1:0] cnt;
    logic             bc_q, me_q, bc_d, me_d, byte_ok;
    int               idx;

    always_comb idx = (st == RX_IDLE) ? 0 : int'(cnt);

    // per-byte acceptance test
    always_comb begin
        byte_ok = 1'b1;
        bc_d    = bc_q;
        me_d    = me_q;
        if (idx < 6) begin
            bc_d = ((idx == 0) ? 1'b1 : bc_q) & (data == 8'hFF);
            me_d = ((idx == 0) ? 1'b1 : me_q) & (data == mac_byte(my_mac, idx));
        end else if (idx == 6) begin
            byte_ok = bc_q | me_q;
        end else if (idx >= 12 && idx < 22) begin
            byte_ok = (data == fixed_hdr(idx, 1'b0));
        end else if (idx >= 38) begin
            byte_ok = (data == ip_byte(my_ip, idx - 38));
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_IDLE:  if (valid) st_nx = byte_ok ? RX_PARSE : RX_DRAIN;
            RX_PARSE: begin
                if (!valid)                       st_nx = RX_IDLE;
                else if (!byte_ok || idx == LAST) st_nx = RX_DRAIN;
            end
            RX_DRAIN: if (!valid) st_nx = RX_IDLE;
            default:  st_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst_async) begin
        if (rst_async) st <= RX_IDLE;
        else           st <= st_nx;
    end

    always_comb commit = (st == RX_PARSE) && valid && byte_ok && (idx == LAST) && !busy;

    always_ff @(posedge clk or posedge rst_async) begin
        if (rst_async) begin
            cnt  <= '0;
            bc_q <= 1'b0;
            me_q <= 1'b0;
            peer <= '0;
        end else if (valid && st != RX_DRAIN) begin
            cnt  <= (st == RX_IDLE) ? CNT_W'(1) : cnt + CNT_W'(1);
            bc_q <= bc_d;
            me_q <= me_d;
            if (idx >= 22 && idx < 28) peer.mac <= {peer.mac[39:0], data};
            if (idx >= 28 && idx < 32) peer.ip  <= {peer.ip[23:0], data};
        end
    end

endmodule

// File: rtl/arp_toggle_link.sv
module arp_toggle_link
    import arp_resp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  rx_clk,
    input  logic  tx_clk,
    input  logic  rst_async,
    input  logic  commit,
    input  peer_t peer_in,
    output logic  busy,
    output logic  start,
    output peer_t peer_out,
    input  logic  done
);
    logic                   req_tgl, ack_tgl, req_seen;
    logic [SYNC_STAGES-1:0] req_sync, ack_sync;
    peer_t                  hold;

    // receive domain: raise request, watch returning acknowledge
    always_ff @(posedge rx_clk or posedge rst_async) begin
        if (rst_async) begin
            req_tgl  <= 1'b0;
            hold     <= '0;
            ack_sync <= '0;
        end else begin
            ack_sync <= {ack_sync[SYNC_STAGES-2:0], ack_tgl};
            if (commit) begin
                req_tgl <= ~req_tgl;
                hold    <= peer_in;
            end
        end
    end

    always_comb busy = req_tgl != ack_sync[SYNC_STAGES-1];

    // transmit domain: detect request edge, toggle acknowledge when sent
    always_ff @(posedge tx_clk or posedge rst_async) begin
        if (rst_async) begin
            req_sync <= '0;
            req_seen <= 1'b0;
            ack_tgl  <= 1'b0;
        end else begin
            req_sync <= {req_sync[SYNC_STAGES-2:0], req_tgl};
            req_seen <= req_sync[SYNC_STAGES-1];
            if (done) ack_tgl <= ~ack_tgl;
        end
    end

    always_comb start    = req_sync[SYNC_STAGES-1] != req_seen;
    always_comb peer_out = hold;

endmodule

// File: rtl/arp_tx_framer.sv
module arp_tx_framer
    import arp_resp_pkg::*;
#(
    parameter int MIN_FRAME = 60
) (
    input  logic        clk,
    input  logic        rst_async,
    input  logic        start,
    input  peer_t       peer_in,
    input  logic [47:0] my_mac,
    input  logic [31:0] my_ip,
    input  logic        ack,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        done
);
    localparam int               CNT_W = $clog2(MIN_FRAME);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(MIN_FRAME - 1);

    tx_state_t        st, st_nx;
    logic [CNT_W-1:0] cnt;
    peer_t            peer_q;

    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE:  if (start) st_nx = TX_OFFER;
            TX_OFFER: if (ack) st_nx = TX_SEND;
            TX_SEND:  if (cnt == LAST) st_nx = TX_IDLE;
            default:  st_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst_async) begin
        if (rst_async) st <= TX_IDLE;
        else           st <= st_nx;
    end

    always_ff @(posedge clk or posedge rst_async) begin
        if (rst_async) begin
            cnt    <= '0;
            peer_q <= '0;
        end else if (st == TX_IDLE && start) begin
            cnt    <= '0;
            peer_q <= peer_in;
        end else if (st == TX_OFFER && ack) begin
            cnt <= CNT_W'(1);
        end else if (st == TX_SEND) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_comb begin
        tx_valid = (st != TX_IDLE);
        tx_data  = (st == TX_IDLE) ? 8'h00 : reply_byte(int'(cnt), my_mac, my_ip, peer_q);
        done     = (st == TX_SEND) && (cnt == LAST);
    end

endmodule

// File: rtl/arp_reply_engine.sv
module arp_reply_engine
    import arp_resp_pkg::*;
#(
    parameter int MIN_FRAME   = 60,
    parameter int SYNC_STAGES = 2
) (
    input  logic        rst_async,
    input  logic [47:0] local_mac,
    input  logic [31:0] local_ip,
    input  logic        rx_clk,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        tx_clk,
    input  logic        tx_ack,
    output logic        tx_valid,
    output logic [7:0]  tx_data
);
    logic  commit, busy, start, done;
    peer_t rx_peer, tx_peer;

    arp_rx_parser u_parser (
        .clk       (rx_clk),
        .rst_async (rst_async),
        .valid     (rx_valid),
        .data      (rx_data),
        .my_mac    (local_mac),
        .my_ip     (local_ip),
        .busy      (busy),
        .commit    (commit),
        .peer      (rx_peer)
    );

    arp_toggle_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
        .rx_clk    (rx_clk),
        .tx_clk    (tx_clk),
        .rst_async (rst_async),
        .commit    (commit),
        .peer_in   (rx_peer),
        .busy      (busy),
        .start     (start),
        .peer_out  (tx_peer),
        .done      (done)
    );

    arp_tx_framer #(.MIN_FRAME(MIN_FRAME)) u_framer (
        .clk       (tx_clk),
        .rst_async (rst_async),
        .start     (start),
        .peer_in   (tx_peer),
        .my_mac    (local_mac),
        .my_ip     (local_ip),
        .ack       (tx_ack),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .done      (done)
    );

endmodule

// File: rtl/arp_reply_engine_chk.sv
module arp_reply_engine_chk #(
    parameter int MIN_FRAME = 60
) (
    input logic       tx_clk,
    input logic       rst_async,
    input logic       tx_valid,
    input logic       tx_ack,
    input logic [7:0] tx_data
);
    logic       sending;
    logic [6:0] sent;

    always_ff @(posedge tx_clk or posedge rst_async) begin
        if (rst_async) begin
            sending <= 1'b0;
            sent    <= '0;
        end else if (!tx_valid) begin
            sending <= 1'b0;
        end else if (!sending && tx_ack) begin
            sending <= 1'b1;
            sent    <= 7'd1;
        end else if (sending) begin
            sent <= sent + 7'd1;
        end
    end

    // R2: frame ends only after the full minimum length
    assert_frame_len_R2: assert property (@(posedge tx_clk) disable iff (rst_async)
        $fell(tx_valid) |-> sent == 7'(MIN_FRAME));

    // R2: padding beyond the ARP payload is zero
    assert_pad_zero_R2: assert property (@(posedge tx_clk) disable iff (rst_async)
        (tx_valid && sending && sent >= 7'd42) |-> tx_data == 8'h00);

    // R3: offered byte holds until acknowledged
    assert_offer_hold_R3: assert property (@(posedge tx_clk) disable iff (rst_async)
        (tx_valid && !sending && !tx_ack) |=> (tx_valid && $stable(tx_data)));

    // R1: EtherType high byte of the reply
    assert_ethertype_R1: assert property (@(posedge tx_clk) disable iff (rst_async)
        (tx_valid && sending && sent == 7'd12) |-> tx_data == 8'h08);

    // R1: opcode low byte marks a reply
    assert_opcode_R1: assert property (@(posedge tx_clk) disable iff (rst_async)
        (tx_valid && sending && sent == 7'd21) |-> tx_data == 8'h02);

endmodule

bind arp_reply_engine arp_reply_engine_chk u_chk (
    .tx_clk    (tx_clk),
    .rst_async (rst_async),
    .tx_valid  (tx_valid),
    .tx_ack    (tx_ack),
    .tx_data   (tx_data)
);

// File: tb/arp_reply_engine_tb.sv
`timescale 1ns/1ps
module arp_reply_engine_tb;

    localparam logic [47:0] MY_MAC  = 48'h02_1A_3C_00_5E_77;
    localparam logic [31:0] MY_IP   = 32'hC0_A8_01_02;
    localparam logic [47:0] BCAST   = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] A_MAC   = 48'h0A_11_22_33_44_55;
    localparam logic [31:0] A_IP    = 32'hC0_A8_01_07;
    localparam logic [47:0] B_MAC   = 48'h0A_66_77_88_99_AA;
    localparam logic [31:0] B_IP    = 32'hC0_A8_01_09;

    logic       clk = 1'b0;
    logic       rst_async = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_ack = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       rx_clk, tx_clk;

    always #4 clk = ~clk;
    assign rx_clk = clk;
    assign tx_clk = ~clk;

    arp_reply_engine u_dut (
        .rst_async (rst_async),
        .local_mac (MY_MAC),
        .local_ip  (MY_IP),
        .rx_clk    (rx_clk),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .tx_clk    (tx_clk),
        .tx_ack    (tx_ack),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

    int total = 0;
    int fails = 0;
    logic [7:0] frm [0:127];
    int flen;

    task automatic check(input bit ok, input string msg, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
        end
    endtask

    task automatic build_req(input logic [47:0] dst, input logic [47:0] smac,
                             input logic [31:0] sip, input logic [31:0] tip);
        logic [42*8-1:0] f;
        f = {dst, smac, 16'h0806, 16'h0001, 16'h0800, 8'h06, 8'h04, 16'h0001,
             smac, sip, 48'h0, tip};
        for (int i = 0; i < 42; i++) frm[i] = f[(41-i)*8 +: 8];
        flen = 42;
    endtask

    task automatic build_ipv4(input int payload);
        logic [14*8-1:0] h;
        h = {MY_MAC, A_MAC, 16'h0800};
        for (int i = 0; i < 14; i++) frm[i] = h[(13-i)*8 +: 8];
        for (int i = 0; i < payload; i++) frm[14+i] = 8'(i);
        for (int i = 0; i < 4; i++) frm[14+payload+i] = 8'(240 + i);
        flen = 18 + payload;
    endtask

    task automatic send_frame();
        for (int i = 0; i < flen; i++) begin
            @(negedge rx_clk);
            rx_valid = 1'b1;
            rx_data  = frm[i];
        end
        @(negedge rx_clk);
        rx_valid = 1'b0;
        rx_data  = 8'h00;
        repeat (2) @(negedge rx_clk);
    endtask

    task automatic expect_none(input string tag);
        int seen = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge tx_clk);
            if (tx_valid) seen++;
        end
        check(seen == 0, {tag, " no reply expected"}, seen, 0);
    endtask

    task automatic expect_reply(input logic [47:0] mac, input logic [31:0] ip,
                                input string tag, input int hold);
        logic [42*8-1:0] f;
        logic [7:0] exp [0:59];
        int waited = 0;
        int bad_offer = 0;
        int bad_hdr = 0;
        int bad_pad = 0;
        int bad_valid = 0;
        f = {mac, MY_MAC, 16'h0806, 16'h0001, 16'h0800, 8'h06, 8'h04, 16'h0002,
             MY_MAC, MY_IP, mac, ip};
        for (int i = 0; i < 60; i++) exp[i] = (i < 42) ? f[(41-i)*8 +: 8] : 8'h00;
        @(negedge tx_clk);
        while (!tx_valid && waited < 80) begin
            @(negedge tx_clk);
            waited++;
        end
        check(tx_valid, {tag, " R3 reply offered"}, tx_valid, 1);
        if (!tx_valid) return;
        for (int i = 0; i < hold; i++) begin
            if (!tx_valid || tx_data != exp[0]) bad_offer++;
            @(negedge tx_clk);
        end
        check(bad_offer == 0 && tx_data == exp[0], {tag, " R3 offer holds byte 0"}, tx_data, exp[0]);
        tx_ack = 1'b1;
        @(negedge tx_clk);
        tx_ack = 1'b0;
        for (int i = 1; i < 60; i++) begin
            if (!tx_valid) bad_valid++;
            if (i < 42 && tx_data != exp[i]) begin
                if (bad_hdr == 0)
                    $display("  byte %0d actual %0h expected %0h", i, tx_data, exp[i]);
                bad_hdr++;
            end
            if (i >= 42 && tx_data != 8'h00) bad_pad++;
            @(negedge tx_clk);
        end
        check(bad_valid == 0, {tag, " R3 valid through frame"}, bad_valid, 0);
        check(bad_hdr == 0, {tag, " R1 reply content"}, bad_hdr, 0);
        check(bad_pad == 0, {tag, " R2 zero padding"}, bad_pad, 0);
        check(!tx_valid, {tag, " R2 valid falls after 60 bytes"}, tx_valid, 0);
    endtask

    task automatic do_reset();
        rst_async = 1'b1;
        repeat (4) @(negedge rx_clk);
        rst_async = 1'b0;
        repeat (2) @(negedge rx_clk);
    endtask

    task automatic t_reset_state();
        @(negedge tx_clk);
        check(!tx_valid, "R11 tx_valid low after reset", tx_valid, 0);
    endtask

    task automatic t_basic();
        build_req(BCAST, A_MAC, A_IP, MY_IP);
        send_frame();
        expect_reply(A_MAC, A_IP, "basic", 10);
    endtask

    task automatic t_dest_mac();
        build_req(MY_MAC, B_MAC, B_IP, MY_IP);
        send_frame();
        expect_reply(B_MAC, B_IP, "R7 unicast dst", 3);
        build_req(48'h02_1A_3C_00_5E_78, A_MAC, A_IP, MY_IP);
        send_frame();
        expect_none("R7 foreign dst");
    endtask

    task automatic t_non_arp();
        build_ipv4(46);
        send_frame();
        expect_none("R4 ipv4 46");
        build_ipv4(76);
        send_frame();
        expect_none("R4 ipv4 76");
        build_req(BCAST, A_MAC, A_IP, MY_IP);
        send_frame();
        expect_reply(A_MAC, A_IP, "R4 after non-arp", 2);
    endtask

    task automatic t_target_ip();
        build_req(BCAST, A_MAC, A_IP, MY_IP ^ 32'h1);
        send_frame();
        expect_none("R5 last byte differs");
        build_req(BCAST, A_MAC, A_IP, MY_IP ^ 32'h0100_0000);
        send_frame();
        expect_none("R5 first byte differs");
    endtask

    task automatic t_bad_fields();
        build_req(BCAST, A_MAC, A_IP, MY_IP);
        frm[21] = 8'h02;
        send_frame();
        expect_none("R6 opcode reply");
        build_req(BCAST, A_MAC, A_IP, MY_IP);
        frm[18] = 8'h08;
        send_frame();
        expect_none("R6 hw length");
        build_req(BCAST, A_MAC, A_IP, MY_IP);
        frm[17] = 8'h06;
        send_frame();
        expect_none("R6 protocol type");
    endtask

    task automatic t_truncated();
        build_req(BCAST, A_MAC, A_IP, MY_IP);
        flen = 41;
        send_frame();
        expect_none("R8 truncated frame");
        build_req(BCAST, B_MAC, B_IP, MY_IP);
        send_frame();
        expect_reply(B_MAC, B_IP, "R8 after truncated", 1);
    endtask

    task automatic t_long();
        build_req(BCAST, A_MAC, A_IP, MY_IP);
        for (int i = 42; i < 64; i++) frm[i] = 8'hA5;
        flen = 64;
        send_frame();
        expect_reply(A_MAC, A_IP, "R9 trailing bytes", 4);
    endtask

    task automatic t_pending();
        int waited = 0;
        build_req(BCAST, A_MAC, A_IP, MY_IP);
        send_frame();
        while (!tx_valid && waited < 80) begin
            @(negedge tx_clk);
            waited++;
        end
        build_req(BCAST, B_MAC, B_IP, MY_IP);
        send_frame();
        expect_reply(A_MAC, A_IP, "R10 first kept", 2);
        expect_none("R10 second dropped");
    endtask

    task automatic t_back_to_back();
        build_req(BCAST, A_MAC, A_IP, MY_IP);
        send_frame();
        expect_reply(A_MAC, A_IP, "R12 first", 10);
        repeat (10) @(negedge rx_clk);
        build_req(BCAST, B_MAC, B_IP, MY_IP);
        send_frame();
        expect_reply(B_MAC, B_IP, "R12 second", 10);
    endtask

    task automatic t_reset_mid();
        int waited = 0;
        build_req(BCAST, A_MAC, A_IP, MY_IP);
        send_frame();
        while (!tx_valid && waited < 80) begin
            @(negedge tx_clk);
            waited++;
        end
        rst_async = 1'b1;
        @(negedge tx_clk);
        check(!tx_valid, "R11 reset drops tx_valid", tx_valid, 0);
        repeat (3) @(negedge rx_clk);
        rst_async = 1'b0;
        expect_none("R11 pending cleared");
        build_req(BCAST, B_MAC, B_IP, MY_IP);
        send_frame();
        expect_reply(B_MAC, B_IP, "R11 after reset", 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        do_reset();
        t_reset_state();
        t_basic();
        t_dest_mac();
        t_non_arp();
        t_target_ip();
        t_bad_fields();
        t_truncated();
        t_long();
        t_pending();
        t_back_to_back();
        t_reset_mid();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule